// File: doc/BRIEF.md
# Two-Step Flash Command Interpreter

This block is the command front end of a small on-chip nonvolatile byte store. A host issues write cycles (address plus data) and read cycles (address) on a simple strobed port. Write data is decoded as command bytes. Sector erase and byte program each need a setup write followed by an execute write. Single-write commands cover reset, attribute-space select, identification read and a one-shot erase-verify read. A permit input from an external protect block gates the execute step of program and erase.

A program or erase runs a busy timer whose length is a parameter in clock cycles. While it runs, `ready` is low and reads return status instead of plain data. Bits 3 and 7 of the last written location read inverted, and bits 2 and 6 of every read flip from one read to the next. An erase can be cut short by a reset write; a program cannot. The storage is a common array plus a smaller attribute array. The attribute array is selected by a sticky mode that only a reset write clears.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `ready` is 1, `rd_data` is 00h and the common array is selected; `rd_data` loads only on a clock edge that samples `rd_en` high, one cycle after the request, and otherwise holds.
- R2: A write of 22h followed by a write of DDh sets every byte of the sector named by `wr_addr[AW-1:SECT_BITS]` of the DDh write to FFh, and leaves bytes of other sectors unchanged.
- R3: After 22h, any execute byte other than DDh or FFh erases nothing and returns to read mode, so a later lone DDh write also erases nothing.
- R4: A write of 11h followed by one more write stores that write's data byte at that write's address.
- R5: A write of FFh right after 22h or 11h aborts the operation, leaves the storage unchanged and returns to read mode.
- R6: `ready` is low for exactly PROG_CYC cycles after a program execute write and ERASE_CYC cycles after an erase execute write; writes made while a program is busy are ignored.
- R7: A write of FFh while an erase is busy ends it, with `ready` high in the cycle after that write.
- R8: While busy, a read of the location named by the execute write returns the true data with bits 3 and 7 inverted; other locations show true data on those bits.
- R9: While busy, bits 2 and 6 of each read are 0 on the first read after the execute write and invert on each further read; once `ready` is high again, reads return plain data.
- R10: A write of 88h makes reads, programs and erases use the attribute array, addressed by `addr[ATTR_AW-1:0]`, until a write of FFh; other commands leave this mode in place.
- R11: After a write of 99h, address 0 reads BFh, address 1 reads 11h and every other address reads 00h. The mode lasts until one of 22h, 11h, FFh, 88h or AAh is written; any other byte leaves it in place.
- R12: After a write of AAh, the next read returns FFh if the addressed byte is FFh and 00h otherwise; the read after that returns plain data.
- R13: When `permit` is low, the execute write of a program or erase changes no storage, does not drop `ready`, and returns to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data / command byte |
| rd_en | input | 1 | Read cycle strobe |
| rd_addr | input | AW | Read address |
| permit | input | 1 | Execute permit from the protect block |
| rd_data | output | 8 | Registered read data or status |
| ready | output | 1 | High when no program or erase is running |

## Verification
The bench aims at the points where a two-step sequencer usually slips. An execute byte that is neither DDh nor FFh must not leave the erase armed, or a stray DDh later would wipe a sector. An abort must not let the next write program. The busy window must end on the exact cycle: a timer that is off by one shows up as a wrong count of low `ready` cycles. The status overlay is checked on the polled and on a neighbouring address, and its toggle phase across successive reads: a design that toggles per cycle instead of per read, or inverts every address, returns wrong bytes. Sticky attribute mode is checked across ID entry and exit, and verify is checked to be one-shot. An ungated execute with `permit` low would alter a stored byte.

// File: rtl/fci_pkg.sv
package fci_pkg;

  typedef enum logic [2:0] {
    ST_READ,
    ST_ERS_SET,
    ST_PGM_SET,
    ST_ERS_BUSY,
    ST_PGM_BUSY,
    ST_ID,
    ST_VERIFY
  } fci_state_e;

  localparam logic [7:0] CMD_ERS_SETUP = 8'h22;
  localparam logic [7:0] CMD_ERS_GO    = 8'hDD;
  localparam logic [7:0] CMD_PGM_SETUP = 8'h11;
  localparam logic [7:0] CMD_RESET     = 8'hFF;
  localparam logic [7:0] CMD_ATTR      = 8'h88;
  localparam logic [7:0] CMD_ID        = 8'h99;
  localparam logic [7:0] CMD_VERIFY    = 8'hAA;

  localparam logic [7:0] ID_MFR    = 8'hBF;
  localparam logic [7:0] ID_DEV    = 8'h11;
  localparam logic [7:0] ERASED    = 8'hFF;
  localparam logic [7:0] POLL_MASK = 8'h88;

endpackage

// File: rtl/fci_timer.sv
module fci_timer #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sel_erase,
  input  logic abort,
  output logic expire,
  output logic running
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (abort)
      cnt_d = '0;
    else if (start)
      cnt_d = sel_erase ? CW'(ERASE_CYC) : CW'(PROG_CYC);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign expire  = (cnt_q == CW'(1));
  assign running = (cnt_q != '0);

endmodule

// File: rtl/fci_seq.sv
module fci_seq
  import fci_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       permit,
  input  logic       expire,
  output fci_state_e state_q,
  output logic       attr_q,
  output logic       do_pgm,
  output logic       do_ers,
  output logic       tmr_start,
  output logic       tmr_erase,
  output logic       tmr_abort
);
  fci_state_e state_d;
  logic       attr_d;

  always_comb begin
    state_d   = state_q;
    attr_d    = attr_q;
    do_pgm    = 1'b0;
    do_ers    = 1'b0;
    tmr_start = 1'b0;
    tmr_erase = 1'b0;
    tmr_abort = 1'b0;
    case (state_q)
      ST_READ, ST_ID, ST_VERIFY: begin
        if (wr_en) begin
          case (wr_data)
            CMD_ERS_SETUP: state_d = ST_ERS_SET;
            CMD_PGM_SETUP: state_d = ST_PGM_SET;
            CMD_RESET: begin
              state_d = ST_READ;
              attr_d  = 1'b0;
            end
            CMD_ATTR: begin
              state_d = ST_READ;
              attr_d  = 1'b1;
            end
            CMD_ID:     state_d = ST_ID;
            CMD_VERIFY: state_d = ST_VERIFY;
            default:    state_d = state_q;
          endcase
        end else if (rd_en && state_q == ST_VERIFY) begin
          state_d = ST_READ;
        end
      end
      ST_ERS_SET: begin
        if (wr_en) begin
          if (wr_data == CMD_ERS_GO && permit) begin
            do_ers    = 1'b1;
            tmr_start = 1'b1;
            tmr_erase = 1'b1;
            state_d   = ST_ERS_BUSY;
          end else begin
            state_d = ST_READ;
            if (wr_data == CMD_RESET) attr_d = 1'b0;
          end
        end
      end
      ST_PGM_SET: begin
        if (wr_en) begin
          if (wr_data == CMD_RESET) begin
            state_d = ST_READ;
            attr_d  = 1'b0;
          end else if (permit) begin
            do_pgm    = 1'b1;
            tmr_start = 1'b1;
            state_d   = ST_PGM_BUSY;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_ERS_BUSY: begin
        if (wr_en && wr_data == CMD_RESET) begin
          tmr_abort = 1'b1;
          attr_d    = 1'b0;
          state_d   = ST_READ;
        end else if (expire) begin
          state_d = ST_READ;
        end
      end
      ST_PGM_BUSY: begin
        if (expire) state_d = ST_READ;
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READ;
      attr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      attr_q  <= attr_d;
    end
  end

  AST_ID_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ID && $past(state_q) != ST_ID) |-> $past(wr_en && wr_data == CMD_ID)); // R11

  AST_ATTR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(attr_q) |-> $past(wr_en && wr_data == CMD_RESET)); // R10

  AST_VERIFY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VERIFY && rd_en && !wr_en) |=> state_q == ST_READ); // R12

  AST_SETUP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PGM_SET || state_q == ST_ERS_SET) && wr_en && wr_data == CMD_RESET)
      |=> (state_q == ST_READ && !attr_q)); // R5

endmodule

// File: rtl/fci_store.sv
module fci_store
  import fci_pkg::*;
#(
  parameter int AW        = 9,
  parameter int ATTR_AW   = 6,
  parameter int SECT_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          attr,
  input  fci_state_e    state,
  input  logic          permit,
  input  logic          pgm_en,
  input  logic          ers_en,
  input  logic          tmr_start,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int CDEPTH = 1 << AW;
  localparam int ADEPTH = 1 << ATTR_AW;
  localparam int DEPTH  = CDEPTH + ADEPTH;
  localparam int PAW    = AW + 1;

  function automatic logic [PAW-1:0] to_phys(input logic sel, input logic [AW-1:0] a);
    logic [PAW-1:0] p;
    if (sel)
      p = PAW'(CDEPTH) | PAW'(a[ATTR_AW-1:0]);
    else
      p = {1'b0, a};
    return p;
  endfunction

  logic [PAW-1:0]           w_phys, r_phys;
  logic [PAW-SECT_BITS-1:0] w_sect;
  logic [7:0]               cells [DEPTH];

  assign w_phys = to_phys(attr, wr_addr);
  assign r_phys = to_phys(attr, rd_addr);
  assign w_sect = w_phys[PAW-1:SECT_BITS];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cell
      localparam logic [PAW-1:0] GA = PAW'(g);
      logic       hit_e, hit_p;
      logic [7:0] cell_q;
      assign hit_e = ers_en && (GA[PAW-1:SECT_BITS] == w_sect);
      assign hit_p = pgm_en && (GA == w_phys);
      always_ff @(posedge clk) begin
        if (hit_e)
          cell_q <= ERASED;
        else if (hit_p)
          cell_q <= wr_data;
      end
      assign cells[g] = cell_q;
    end
  endgenerate

  logic [7:0]     cell_rd, rd_q, rd_d;
  logic           tgl_q, tgl_d;
  logic [PAW-1:0] last_q, last_d;
  logic           busy;

  assign cell_rd = cells[r_phys];
  assign busy    = (state == ST_PGM_BUSY) || (state == ST_ERS_BUSY);

  always_comb begin
    case (state)
      ST_ID: begin
        if (rd_addr == '0)
          rd_d = ID_MFR;
        else if (rd_addr == AW'(1))
          rd_d = ID_DEV;
        else
          rd_d = 8'h00;
      end
      ST_VERIFY: rd_d = (cell_rd == ERASED) ? ERASED : 8'h00;
      ST_PGM_BUSY, ST_ERS_BUSY: begin
        rd_d = cell_rd;
        if (r_phys == last_q) rd_d = rd_d ^ POLL_MASK;
        rd_d[6] = tgl_q;
        rd_d[2] = tgl_q;
      end
      default: rd_d = cell_rd;
    endcase
  end

  always_comb begin
    tgl_d = tgl_q;
    if (tmr_start)
      tgl_d = 1'b0;
    else if (rd_en && busy)
      tgl_d = ~tgl_q;
    last_d = (pgm_en || ers_en) ? w_phys : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 8'h00;
      tgl_q  <= 1'b0;
      last_q <= '0;
    end else begin
      if (rd_en) rd_q <= rd_d;
      tgl_q  <= tgl_d;
      last_q <= last_d;
    end
  end

  assign rd_data = rd_q;

  AST_MEM_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_en || ers_en) |-> permit); // R13

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q)); // R1

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fci_pkg::*;
#(
  parameter int AW        = 9,
  parameter int ATTR_AW   = 6,
  parameter int SECT_BITS = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          permit,
  output logic [7:0]    rd_data,
  output logic          ready
);
  fci_state_e state;
  logic attr, do_pgm, do_ers, tmr_start, tmr_erase, tmr_abort, expire, running;

  fci_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .permit    (permit),
    .expire    (expire),
    .state_q   (state),
    .attr_q    (attr),
    .do_pgm    (do_pgm),
    .do_ers    (do_ers),
    .tmr_start (tmr_start),
    .tmr_erase (tmr_erase),
    .tmr_abort (tmr_abort)
  );

  fci_timer #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (tmr_start),
    .sel_erase (tmr_erase),
    .abort     (tmr_abort),
    .expire    (expire),
    .running   (running)
  );

  fci_store #(
    .AW        (AW),
    .ATTR_AW   (ATTR_AW),
    .SECT_BITS (SECT_BITS)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .attr      (attr),
    .state     (state),
    .permit    (permit),
    .pgm_en    (do_pgm),
    .ers_en    (do_ers),
    .tmr_start (tmr_start),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  assign ready = !((state == ST_PGM_BUSY) || (state == ST_ERS_BUSY));

  AST_PGM_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PGM_BUSY && !expire) |=> state == ST_PGM_BUSY); // R6

  AST_BUSY_HAS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> running); // R6

  AST_ERS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERS_BUSY && wr_en && wr_data == CMD_RESET) |=> ready); // R7

endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/100ps
module sim_flash_cmd_ctrl;
  localparam int AW = 9;
  localparam int PROG_CYC = 8;
  localparam int ERASE_CYC = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = 8'h00;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          permit = 1'b1;
  logic [7:0]    rd_data;
  logic          ready;

  int checks = 0;
  int errors = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(
    .AW (AW), .ATTR_AW (6), .SECT_BITS (4),
    .PROG_CYC (PROG_CYC), .ERASE_CYC (ERASE_CYC)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_en (rd_en), .rd_addr (rd_addr),
    .permit (permit), .rd_data (rd_data), .ready (ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    got = rd_data;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (ready == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] busy_view(input logic [7:0] d, input logic same, input logic t);
    logic [7:0] r;
    r = same ? (d ^ 8'h88) : d;
    r[6] = t;
    r[2] = t;
    return r;
  endfunction

  task automatic t_reset();
    chk("R1 reset rd_data", int'(rd_data), 'h00);
    chk("R1 reset ready", int'(ready), 1);
  endtask

  task automatic t_erase();
    int n;
    wr('h003, 8'h22); wr('h003, 8'hDD);
    wait_ready(n);
    chk("R6 erase busy length", n, ERASE_CYC);
    wr('h010, 8'h22); wr('h010, 8'hDD); wait_ready(n);
    wr('h000, 8'h11); wr('h012, 8'hA5); wait_ready(n);
    wr('h00A, 8'h22); wr('h00A, 8'hDD); wait_ready(n);
    rd('h012); chk("R2 other sector untouched", int'(got), 'hA5);
    rd('h000); chk("R2 sector low byte erased", int'(got), 'hFF);
    rd('h00F); chk("R2 sector top byte erased", int'(got), 'hFF);
  endtask

  task automatic t_program();
    int n;
    wr('h000, 8'h11); wr('h005, 8'h3C);
    wait_ready(n);
    chk("R6 program busy length", n, PROG_CYC);
    rd('h005); chk("R4 programmed byte", int'(got), 'h3C);
    repeat (3) @(negedge clk);
    chk("R1 rd_data holds without rd_en", int'(rd_data), 'h3C);
  endtask

  task automatic t_wrong_exec();
    wr('h005, 8'h22); wr('h005, 8'h55);
    chk("R3 no busy after bad execute", int'(ready), 1);
    wr('h005, 8'hDD);
    chk("R3 lone DDh no busy", int'(ready), 1);
    rd('h005); chk("R3 nothing erased", int'(got), 'h3C);
  endtask

  task automatic t_abort();
    wr('h005, 8'h22); wr('h005, 8'hFF);
    rd('h005); chk("R5 erase abort keeps data", int'(got), 'h3C);
    wr('h000, 8'h11); wr('h006, 8'hFF);
    wr('h006, 8'h42);
    chk("R5 no busy after program abort", int'(ready), 1);
    rd('h006); chk("R5 program abort stores nothing", int'(got), 'hFF);
  endtask

  task automatic t_poll();
    int n;
    wr('h000, 8'h11); wr('h007, 8'h5A);
    rd('h007); chk("R8 poll first read", int'(got), int'(busy_view(8'h5A, 1'b1, 1'b0)));
    rd('h007); chk("R9 toggle second read", int'(got), int'(busy_view(8'h5A, 1'b1, 1'b1)));
    rd('h008); chk("R8 other address true bits 3 7", int'(got), int'(busy_view(8'hFF, 1'b0, 1'b0)));
    wr('h000, 8'h99);
    wait_ready(n);
    rd('h007); chk("R9 plain data after busy", int'(got), 'h5A);
    rd('h000); chk("R6 write during program busy ignored", int'(got), 'hFF);
  endtask

  task automatic t_erase_abort();
    wr('h013, 8'h22); wr('h013, 8'hDD);
    rd('h013); chk("R8 erase poll", int'(got), int'(busy_view(8'hFF, 1'b1, 1'b0)));
    wr('h013, 8'hFF);
    chk("R7 ready after reset during erase", int'(ready), 1);
    rd('h012); chk("R7 sector erased", int'(got), 'hFF);
  endtask

  task automatic t_attr();
    int n;
    wr('h000, 8'h88);
    wr('h000, 8'h22); wr('h000, 8'hDD); wait_ready(n);
    wr('h000, 8'h11); wr('h002, 8'h11); wait_ready(n);
    rd('h002); chk("R10 attribute read", int'(got), 'h11);
    wr('h000, 8'h99);
    rd('h000); chk("R11 ID in attribute mode", int'(got), 'hBF);
    wr('h000, 8'h88);
    rd('h002); chk("R10 attribute kept after ID", int'(got), 'h11);
    wr('h000, 8'hFF);
    rd('h002); chk("R10 reset returns to common", int'(got), 'hFF);
  endtask

  task automatic t_id();
    wr('h000, 8'h99);
    rd('h000); chk("R11 mfr code", int'(got), 'hBF);
    rd('h001); chk("R11 dev code", int'(got), 'h11);
    rd('h002); chk("R11 other address", int'(got), 'h00);
    wr('h000, 8'h5E);
    rd('h000); chk("R11 invalid byte keeps ID", int'(got), 'hBF);
    wr('h000, 8'hFF);
    rd('h000); chk("R11 reset leaves ID", int'(got), 'hFF);
  endtask

  task automatic t_verify();
    wr('h000, 8'hAA);
    rd('h005); chk("R12 verify not erased", int'(got), 'h00);
    rd('h005); chk("R12 verify one-shot", int'(got), 'h3C);
    wr('h000, 8'hAA);
    rd('h000); chk("R12 verify erased", int'(got), 'hFF);
  endtask

  task automatic t_permit();
    permit = 1'b0;
    wr('h000, 8'h11); wr('h005, 8'h00);
    chk("R13 no busy on blocked program", int'(ready), 1);
    rd('h005); chk("R13 blocked program", int'(got), 'h3C);
    wr('h005, 8'h22); wr('h005, 8'hDD);
    chk("R13 no busy on blocked erase", int'(ready), 1);
    rd('h005); chk("R13 blocked erase", int'(got), 'h3C);
    permit = 1'b1;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_erase();
    t_program();
    t_wrong_exec();
    t_abort();
    t_poll();
    t_erase_abort();
    t_attr();
    t_id();
    t_verify();
    t_permit();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule